// File: doc/BRIEF.md
# FPU Register Half-Word Access Unit

This unit sits between the integer datapath and a 64-bit floating-point register file. It handles 32-bit moves, word loads, word stores, 64-bit moves, and reads and writes of the floating-point control registers. It registers every result, so each accepted operation shows its outputs one clock later.

The unit has two register modes, chosen by `mode_full`. Elsewhere in the system that input is driven from bit 26 of the processor status register. In full mode every register index names a complete 64-bit register. In paired mode an odd index names the upper half of the even register just below it. A 32-bit write in paired mode is then merged into the current contents of that even register, and only the addressed half changes.

The control/status word is held inside the unit. A write to it takes one cycle to commit. A read issued while a write is still pending returns the pending value.

The operation codes on `op_code` are:

| Code | Operation |
|------|-----------|
| 0 | 32-bit move-to |
| 1 | 32-bit move-from |
| 2 | word load |
| 3 | word store |
| 4 | control read |
| 5 | control write |
| 6 | 64-bit move-to (also used for double loads) |
| 7 | 64-bit move-from (also used for double stores) |

Top module: `fpu_half_xfer`

## Requirements
- R1: While reset is held and after it is released with no operation issued, every output is zero. A control read of index 31 (op code 4) issued right after reset returns zero.
- R2: Move-from (op code 1) returns a 32-bit half on `gpr_data`, sign-extended to 64 bits. The half is the upper one when paired mode is selected (`mode_full`=0) and the index is odd; in every other case it is the lower one.
- R3: Move-to (op code 0) in paired mode writes to the index with bit 0 cleared. For an odd index, `int_opnd[31:0]` goes into bits 63:32 and bits 31:0 of `reg_cur` are kept. For an even index, `int_opnd[31:0]` goes into bits 31:0 and bits 63:32 of `reg_cur` are kept.
- R4: Move-to (op code 0) in full mode writes `int_opnd[31:0]`, sign-extended to 64 bits, to the unchanged index.
- R5: Word load (op code 2) in paired mode clears bit 0 of the index. `wr_data` holds the kept half of `reg_cur`, with the other half zero. `post_shift` is 32 for an odd index and 0 for an even index. In full mode the load gives `wr_data`=0, `post_shift`=0 and the unchanged index.
- R6: Word store (op code 3) puts `reg_cur` on `st_data`. When paired mode is selected and the index is odd, the value is shifted right by 32 first.
- R7: A control read (op code 4) of index 0 returns the implementation word 0xA00.
- R8: A control read of index 31 returns the control/status word, sign-extended from 32 bits. If a control write was accepted in the cycle just before, the read returns that written value.
- R9: A control write (op code 5) stores `int_opnd[31:0]` only when the index is 31. Writes to any other index leave the control/status word unchanged.
- R10: A control read of any index other than 0 or 31 returns zero and raises `rd_err` for exactly that one result cycle.
- R11: 64-bit move-to (op code 6) writes all of `int_opnd` to the unchanged index. 64-bit move-from (op code 7) returns all of `reg_cur`. Both ignore the mode.
- R12: Results appear one clock after the operation is sampled. `wr_en` is high only for op codes 0, 2 and 6. Outputs that do not apply to an operation are zero. With `op_valid` low, `wr_en` and `rd_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (see table) |
| mode_full | input | 1 | 1: full 64-bit registers, 0: paired halves |
| reg_idx | input | 5 | Floating-point or control register index |
| int_opnd | input | 64 | Operand from the integer side |
| reg_cur | input | 64 | Current contents of the indexed register |
| wr_en | output | 1 | Register-file write request |
| wr_idx | output | 5 | Effective write index |
| wr_data | output | 64 | Merged write value |
| gpr_data | output | 64 | Value returned to the integer side |
| st_data | output | 64 | Store data |
| post_shift | output | 6 | Left shift the memory stage applies to load data |
| rd_err | output | 1 | Reserved control read |

## Verification
The bench uses the default parameters: 64-bit registers, a 5-bit index, control index 31 and implementation word 0xA00. With these values, indices 0 and 31 can be compared against a reserved index such as 12. Odd and even indices cover both halves in each mode, and sign bits at bit 31 show whether a value was sign-extended. The bench issues a control write and a control read back to back, which exercises the forwarding path. It then reads again after the write has committed.

// File: rtl/fpu_half_xfer.sv
module fpu_half_xfer #(
  parameter int XLEN = 64,
  parameter int IDXW = 5,
  parameter int CSR_IDX = 31,
  parameter logic [31:0] IMPL_WORD = 32'h0000_0A00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic            mode_full,
  input  logic [IDXW-1:0] reg_idx,
  input  logic [XLEN-1:0] int_opnd,
  input  logic [XLEN-1:0] reg_cur,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] gpr_data,
  output logic [XLEN-1:0] st_data,
  output logic [$clog2(XLEN)-1:0] post_shift,
  output logic            rd_err
);
  localparam int HW  = XLEN / 2;
  localparam int SHW = $clog2(XLEN);
  localparam logic [2:0] OP_MTO = 3'd0, OP_MFROM = 3'd1, OP_LDW = 3'd2, OP_STW = 3'd3,
                         OP_CRD = 3'd4, OP_CWR = 3'd5, OP_DMTO = 3'd6, OP_DMFROM = 3'd7;

  logic [HW-1:0] csr_q, pend_d, csr_view;
  logic          pend_v;

  wire paired  = !mode_full;
  wire odd     = reg_idx[0];
  wire hi_sel  = paired && odd;
  wire [IDXW-1:0] even_idx = {reg_idx[IDXW-1:1], 1'b0};
  wire [HW-1:0] cur_lo = reg_cur[HW-1:0];
  wire [HW-1:0] cur_hi = reg_cur[XLEN-1:HW];
  wire [HW-1:0] opd_lo = int_opnd[HW-1:0];
  wire is_csr  = reg_idx == IDXW'(CSR_IDX);
  wire is_impl = reg_idx == '0;

  assign csr_view = pend_v ? pend_d : csr_q;

  function automatic logic [XLEN-1:0] sext(input logic [HW-1:0] v);
    return {{HW{v[HW-1]}}, v};
  endfunction

  logic            n_wen, n_err;
  logic [IDXW-1:0] n_widx;
  logic [XLEN-1:0] n_wdata, n_gpr, n_st;
  logic [SHW-1:0]  n_shift;

  always_comb begin
    n_wen = 1'b0; n_err = 1'b0; n_widx = '0; n_shift = '0;
    n_wdata = '0; n_gpr = '0; n_st = '0;
    unique case (op_code)
      OP_MTO: begin
        n_wen = 1'b1;
        if (paired) begin
          n_widx  = even_idx;
          n_wdata = odd ? {opd_lo, cur_lo} : {cur_hi, opd_lo};
        end else begin
          n_widx  = reg_idx;
          n_wdata = sext(opd_lo);
        end
      end
      OP_MFROM: n_gpr = sext(hi_sel ? cur_hi : cur_lo);
      OP_LDW: begin
        n_wen = 1'b1;
        if (paired) begin
          n_widx  = even_idx;
          n_wdata = odd ? {{HW{1'b0}}, cur_lo} : {cur_hi, {HW{1'b0}}};
          n_shift = odd ? SHW'(HW) : '0;
        end else begin
          n_widx  = reg_idx;
        end
      end
      OP_STW: n_st = hi_sel ? (reg_cur >> HW) : reg_cur;
      OP_CRD: begin
        if (is_impl)     n_gpr = sext(HW'(IMPL_WORD));
        else if (is_csr) n_gpr = sext(csr_view);
        else             n_err = 1'b1;
      end
      OP_CWR: ;
      OP_DMTO: begin
        n_wen   = 1'b1;
        n_widx  = reg_idx;
        n_wdata = int_opnd;
      end
      OP_DMFROM: n_gpr = reg_cur;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q  <= '0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else begin
      if (pend_v) csr_q <= pend_d;
      pend_v <= op_valid && op_code == OP_CWR && is_csr;
      if (op_valid && op_code == OP_CWR && is_csr) pend_d <= opd_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0; rd_err <= 1'b0; wr_idx <= '0; post_shift <= '0;
      wr_data <= '0; gpr_data <= '0; st_data <= '0;
    end else if (op_valid) begin
      wr_en <= n_wen; rd_err <= n_err; wr_idx <= n_widx; post_shift <= n_shift;
      wr_data <= n_wdata; gpr_data <= n_gpr; st_data <= n_st;
    end else begin
      wr_en <= 1'b0; rd_err <= 1'b0;
    end
  end

  a_r3_paired_write_even: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !mode_full && op_code == OP_MTO) |=> (wr_en && !wr_idx[0]));

  a_r10_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CRD && !is_impl && !is_csr) |=> (rd_err && gpr_data == '0));

  a_r10_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(op_valid && op_code == OP_CRD));

  a_r11_double_move: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_DMTO) |=> (wr_data == $past(int_opnd) && wr_idx == $past(reg_idx)));

  a_r6_odd_store: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_STW && !mode_full && reg_idx[0]) |=> (st_data == ($past(reg_cur) >> HW)));

  a_r9_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CWR && !is_csr) |=> !pend_v);

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wr_en && !rd_err));
endmodule

// File: tb/fpu_half_xfer_test.sv
module fpu_half_xfer_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 15;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, mode_full = 1'b0;
  logic [2:0] op_code = '0;
  logic [4:0] reg_idx = '0;
  logic [63:0] int_opnd = '0, reg_cur = '0;
  logic wr_en, rd_err;
  logic [4:0] wr_idx;
  logic [63:0] wr_data, gpr_data, st_data;
  logic [5:0] post_shift;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_half_xfer uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .mode_full(mode_full), .reg_idx(reg_idx), .int_opnd(int_opnd), .reg_cur(reg_cur),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .gpr_data(gpr_data),
    .st_data(st_data), .post_shift(post_shift), .rd_err(rd_err));

  localparam logic [63:0] A = 64'h1234_5678_8765_4321;
  localparam logic [63:0] B = 64'h1111_2222_3333_4444;
  localparam logic [63:0] C = 64'hCAFE_0000_0000_1111;
  localparam logic [63:0] D = 64'hDEAD_BEEF_8000_0001;

  // R2 v0-v2, R4 v3, R3 v4-v5, R5 v6-v8, R6 v9-v11, R11 v12-v13, R7 v14
  localparam logic [2:0]  V_OP   [0:N-1] = '{1,1,1,0,0,0,2,2,2,3,3,3,6,7,4};
  localparam logic        V_FULL [0:N-1] = '{1,0,0,1,0,0,0,0,1,0,0,1,0,0,0};
  localparam logic [4:0]  V_IDX  [0:N-1] = '{3,3,2,5,5,6,7,4,7,9,8,9,3,3,0};
  localparam logic [63:0] V_OPD  [0:N-1] = '{0,0,0,D,D,D,0,0,0,0,0,0,D,0,0};
  localparam logic [63:0] V_CUR  [0:N-1] = '{A,A,C,B,B,B,B,B,B,B,B,B,B,B,B};
  localparam logic        E_WEN  [0:N-1] = '{0,0,0,1,1,1,1,1,1,0,0,0,1,0,0};
  localparam logic [4:0]  E_WIDX [0:N-1] = '{0,0,0,5,4,6,6,4,7,0,0,0,3,0,0};
  localparam logic [63:0] E_WD   [0:N-1] = '{0,0,0,64'hFFFF_FFFF_8000_0001,
    64'h8000_0001_3333_4444, 64'h1111_2222_8000_0001, 64'h0000_0000_3333_4444,
    64'h1111_2222_0000_0000, 0,0,0,0, D,0,0};
  localparam logic [63:0] E_GPR  [0:N-1] = '{64'hFFFF_FFFF_8765_4321, 64'h0000_0000_1234_5678,
    64'h0000_0000_0000_1111, 0,0,0,0,0,0,0,0,0,0, B, 64'h0000_0000_0000_0A00};
  localparam logic [63:0] E_ST   [0:N-1] = '{0,0,0,0,0,0,0,0,0,64'h0000_0000_1111_2222,B,B,0,0,0};
  localparam logic [5:0]  E_SH   [0:N-1] = '{0,0,0,0,0,0,32,0,0,0,0,0,0,0,0};
  localparam int          V_REQ  [0:N-1] = '{2,2,2,4,3,3,5,5,5,6,6,6,11,11,7};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic full, input logic [4:0] idx,
                       input logic [63:0] opd, input logic [63:0] cur);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; mode_full = full; reg_idx = idx; int_opnd = opd; reg_cur = cur;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({wr_en, rd_err, wr_idx, post_shift} == '0 && wr_data == 0 && gpr_data == 0 && st_data == 0,
        "R1 outputs in reset", {51'd0, wr_en, rd_err, wr_idx, post_shift}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(wr_en == 1'b0 && gpr_data == 0, "R1 idle after reset", gpr_data, 64'd0);
    issue(3'd4, 1'b0, 5'd31, 64'd0, 64'd0);
    chk(gpr_data == 64'd0, "R1 status word after reset", gpr_data, 64'd0);

    for (int i = 0; i < N; i++) begin
      logic [204:0] act, exp;
      issue(V_OP[i], V_FULL[i], V_IDX[i], V_OPD[i], V_CUR[i]);
      act = {wr_en, wr_idx, wr_data, gpr_data, st_data, post_shift, rd_err};
      exp = {E_WEN[i], E_WIDX[i], E_WD[i], E_GPR[i], E_ST[i], E_SH[i], 1'b0};
      checks++;
      if (act !== exp) begin
        fails++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", V_REQ[i], i, act, exp);
      end
    end

    // R8 forwarding: write then read back to back
    issue(3'd5, 1'b0, 5'd31, 64'h0000_0000_8080_0001, 64'd0);
    chk(wr_en == 1'b0, "R12 control write no fpr write", {63'd0, wr_en}, 64'd0);
    issue(3'd4, 1'b0, 5'd31, 64'd0, 64'd0);
    chk(gpr_data == 64'hFFFF_FFFF_8080_0001, "R8 forwarded read", gpr_data, 64'hFFFF_FFFF_8080_0001);
    idle();
    issue(3'd4, 1'b1, 5'd31, 64'd0, 64'd0);
    chk(gpr_data == 64'hFFFF_FFFF_8080_0001, "R8 committed read", gpr_data, 64'hFFFF_FFFF_8080_0001);
    // R9 reserved write discarded
    issue(3'd5, 1'b0, 5'd12, 64'h0000_0000_0000_0055, 64'd0);
    issue(3'd4, 1'b0, 5'd31, 64'd0, 64'd0);
    chk(gpr_data == 64'hFFFF_FFFF_8080_0001, "R9 reserved write ignored", gpr_data, 64'hFFFF_FFFF_8080_0001);
    idle(); idle();
    issue(3'd4, 1'b0, 5'd31, 64'd0, 64'd0);
    chk(gpr_data == 64'hFFFF_FFFF_8080_0001, "R9 reserved write ignored later", gpr_data, 64'hFFFF_FFFF_8080_0001);
    // R10 reserved read
    issue(3'd4, 1'b0, 5'd12, 64'd0, 64'd0);
    chk(rd_err == 1'b1 && gpr_data == 64'd0, "R10 reserved read", gpr_data, 64'd0);
    idle();
    chk(rd_err == 1'b0 && wr_en == 1'b0, "R10 R12 error lasts one cycle", {62'd0, rd_err, wr_en}, 64'd0);
    // R8 positive value, sign extension with bit 31 clear
    issue(3'd5, 1'b1, 5'd31, 64'hFFFF_FFFF_0080_0000, 64'd0);
    idle();
    issue(3'd4, 1'b1, 5'd31, 64'd0, 64'd0);
    chk(gpr_data == 64'h0000_0000_0080_0000, "R8 positive status word", gpr_data, 64'h0000_0000_0080_0000);
    // R12 latency: output unchanged before edge
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'd6; reg_idx = 5'd9; int_opnd = C;
    #1;
    chk(wr_en == 1'b0, "R12 no output before edge", {63'd0, wr_en}, 64'd0);
    @(posedge clk); #1;
    chk(wr_en == 1'b1 && wr_data == C && wr_idx == 5'd9, "R12 R11 output after edge", wr_data, C);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule